// File: doc/BRIEF.md
# Register Locator Entry Walker

This block walks a register-locator structure held in configuration space. After a start pulse it fetches the structure's header dword through a dword read port and takes the total byte length from it. From that length it works out how many 8-byte locator entries follow the 12-byte fixed header. It then fetches the low and high dword of each entry in turn.

For every entry it builds a descriptor. The descriptor carries the BAR indicator and the 64-bit block offset. It also carries a verdict: the entry is accepted only if the indicator names a BAR in the supplied size table and that BAR is not smaller than the offset. Descriptors leave one per valid/ready handshake, in entry order, and the final one is flagged as last.

A structure too short to hold any entry ends the walk right after the header fetch. No locator dword is read in that case.

Top module: `reglocator_walker`

## Requirements
- R1: After reset the block is idle: `busy`, `rd_req`, `desc_valid` and `done` are all low.
- R2: A `start` pulse while idle captures `base_addr`. The first read is the dword at `base_addr + 4`, and the structure length in bytes is taken from bits [31:20] of that dword.
- R3: The entry count is floor((length − 12) / 8). A length below 12 gives zero entries. A 0x14-byte structure yields exactly one entry, and no read is ever issued past the last whole entry.
- R4: Entry k (from 0) has its low dword at `base_addr + 12 + 8k` and its high dword 4 bytes higher; the low dword is read first. Every read address is dword aligned. `rd_req` and `rd_addr` hold steady until `rd_ack`, and `rd_data` is taken in the cycle `rd_ack` is high.
- R5: `desc_bar` is bits [2:0] of the low dword. `desc_offset` is {high dword, low dword bits [31:16], 16'h0000}.
- R6: `desc_ok` is 1 only when the indicator is below `NBAR` and that BAR's 64-bit size (entry i at `bar_size[64*i +: 64]`) is not smaller than the offset. An indicator of `NBAR` or more, or a smaller size, gives `desc_ok` = 0. A size equal to the offset is accepted.
- R7: Descriptors are presented in entry order. Each one stays valid and unchanged until `desc_ready`. `desc_last` is high only on the final entry, and no read is issued while a descriptor is pending.
- R8: `done` pulses for one cycle as the block returns to idle: after the final handshake, or after a header that gives zero entries. A `start` seen while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a walk (idle only) |
| base_addr | input | AW | Byte offset of the structure base |
| rd_req | output | 1 | Dword read request |
| rd_addr | output | AW | Byte address of the requested dword |
| rd_ack | input | 1 | Read completion, qualifies rd_data |
| rd_data | input | 32 | Returned dword |
| bar_size | input | 64*NBAR | Per-BAR size table, BAR i at bits [64*i +: 64] |
| desc_valid | output | 1 | Descriptor available |
| desc_ready | input | 1 | Descriptor accepted |
| desc_bar | output | 3 | BAR indicator of the entry |
| desc_offset | output | 64 | Block offset of the entry |
| desc_ok | output | 1 | Entry fits its BAR |
| desc_last | output | 1 | Final entry of the walk |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle end-of-walk pulse |

## Verification
A wrong remaining-entry count shows at the ports at once. The walk ends early or late, so the number of descriptors and the number of read cycles disagree with the length, and `desc_last` lands on the wrong entry. A wrong address pointer shows on the very next `rd_addr` handed out with an acknowledge. A corrupt captured dword shows on the descriptor that follows within a few cycles. The bench therefore checks every acknowledged address, every accepted descriptor, and the read and descriptor totals for each walk. Lengths at and around the 12-byte and 20-byte boundaries, and sizes one below and equal to the offset, are driven directly.

// File: rtl/reglocator_walker.sv
module reglocator_walker #(
  parameter int AW     = 12,
  parameter int NBAR   = 6,
  parameter int LENW   = 12,
  parameter int LENLSB = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [AW-1:0]    base_addr,
  output logic             rd_req,
  output logic [AW-1:0]    rd_addr,
  input  logic             rd_ack,
  input  logic [31:0]      rd_data,
  input  logic [64*NBAR-1:0] bar_size,
  output logic             desc_valid,
  input  logic             desc_ready,
  output logic [2:0]       desc_bar,
  output logic [63:0]      desc_offset,
  output logic             desc_ok,
  output logic             desc_last,
  output logic             busy,
  output logic             done
);
  localparam int CW = LENW - 3;
  localparam logic [AW-1:0]   HDR1_OFS  = AW'(4);
  localparam logic [AW-1:0]   FIRST_OFS = AW'(12);
  localparam logic [AW-1:0]   ENT_STEP  = AW'(8);
  localparam logic [AW-1:0]   HI_OFS    = AW'(4);
  localparam logic [LENW-1:0] FIXED_LEN = LENW'(12);

  typedef enum logic [2:0] {S_IDLE, S_LEN, S_LO, S_HI, S_OUT} st_t;

  st_t            st;
  logic [AW-1:0]  ptr;
  logic [CW-1:0]  cnt;
  logic [31:0]    lo_q, hi_q;

  logic [LENW-1:0] len_f, body;
  logic [CW-1:0]   n_ent;
  assign len_f = rd_data[LENLSB +: LENW];
  assign body  = len_f - FIXED_LEN;
  assign n_ent = (len_f < FIXED_LEN) ? '0 : body[LENW-1:3];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= S_IDLE;
      ptr  <= '0;
      cnt  <= '0;
      lo_q <= '0;
      hi_q <= '0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          ptr <= base_addr;
          st  <= S_LEN;
        end
        S_LEN: if (rd_ack) begin
          if (n_ent == '0) begin
            st   <= S_IDLE;
            done <= 1'b1;
          end else begin
            cnt <= n_ent;
            ptr <= ptr + FIRST_OFS;
            st  <= S_LO;
          end
        end
        S_LO: if (rd_ack) begin
          lo_q <= rd_data;
          st   <= S_HI;
        end
        S_HI: if (rd_ack) begin
          hi_q <= rd_data;
          st   <= S_OUT;
        end
        S_OUT: if (desc_ready) begin
          if (cnt == CW'(1)) begin
            st   <= S_IDLE;
            done <= 1'b1;
          end else begin
            cnt <= cnt - CW'(1);
            ptr <= ptr + ENT_STEP;
            st  <= S_LO;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign busy   = (st != S_IDLE);
  assign rd_req = (st == S_LEN) || (st == S_LO) || (st == S_HI);

  always_comb begin
    case (st)
      S_LEN:   rd_addr = ptr + HDR1_OFS;
      S_HI:    rd_addr = ptr + HI_OFS;
      default: rd_addr = ptr;
    endcase
  end

  logic        bar_in;
  logic [2:0]  bar_c;
  logic [63:0] sel_size;
  assign desc_bar    = lo_q[2:0];
  assign desc_offset = {hi_q, lo_q[31:16], 16'h0000};
  assign bar_in      = int'(desc_bar) < NBAR;
  assign bar_c       = bar_in ? desc_bar : 3'd0;
  assign sel_size    = bar_size[64*int'(bar_c) +: 64];
  assign desc_ok     = bar_in && !(sel_size < desc_offset);
  assign desc_valid  = (st == S_OUT);
  assign desc_last   = (st == S_OUT) && (cnt == CW'(1));

  a_r4_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req && !rd_ack |=> rd_req && $stable(rd_addr));
  a_r4_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |-> rd_addr[1:0] == 2'b00);
  a_r7_desc_hold: assert property (@(posedge clk) disable iff (!rst_n)
    desc_valid && !desc_ready |=> desc_valid && $stable(desc_offset)
      && $stable(desc_bar) && $stable(desc_ok) && $stable(desc_last));
  a_r7_no_read_pending: assert property (@(posedge clk) disable iff (!rst_n)
    !(desc_valid && rd_req));
  a_r8_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy && $past(busy));
  a_r8_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy && start && !done |=> busy || done);
endmodule

// File: tb/sim_reglocator_walker.sv
`timescale 1ns/1ps
module sim_reglocator_walker;
  localparam int AW = 12, NBAR = 6;

  logic clk = 0, rst_n = 0, start = 0;
  logic [AW-1:0] base_addr = '0;
  logic rd_req, rd_ack = 0;
  logic [AW-1:0] rd_addr;
  logic [31:0] rd_data = '0;
  logic [64*NBAR-1:0] bar_size;
  logic desc_valid, desc_ready = 0, desc_ok, desc_last, busy, done;
  logic [2:0] desc_bar;
  logic [63:0] desc_offset;

  always #4 clk = ~clk;

  reglocator_walker #(.AW(AW), .NBAR(NBAR)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .base_addr(base_addr),
    .rd_req(rd_req), .rd_addr(rd_addr), .rd_ack(rd_ack), .rd_data(rd_data),
    .bar_size(bar_size), .desc_valid(desc_valid), .desc_ready(desc_ready),
    .desc_bar(desc_bar), .desc_offset(desc_offset), .desc_ok(desc_ok),
    .desc_last(desc_last), .busy(busy), .done(done));

  logic [31:0] mem [0:1023];
  logic [63:0] bsz [0:NBAR-1];
  always_comb for (int i = 0; i < NBAR; i++) bar_size[64*i +: 64] = bsz[i];

  int checks = 0, errors = 0;
  int ai, di, exp_n;
  int cur_base;
  bit pv;
  logic [63:0] poff;

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] e_off(input logic [31:0] lo, input logic [31:0] hi);
    return {hi, lo[31:16], 16'h0000};
  endfunction
  function automatic bit e_ok(input logic [31:0] lo, input logic [31:0] hi);
    if (int'(lo[2:0]) >= NBAR) return 1'b0;
    return !(bsz[lo[2:0]] < e_off(lo, hi));
  endfunction

  always @(posedge clk) begin
    rd_ack <= 1'b0;
    if (rd_req && !rd_ack && ($urandom % 3 == 0)) begin
      rd_ack  <= 1'b1;
      rd_data <= mem[rd_addr[11:2]];
    end
    desc_ready <= ($urandom % 2) == 0;
  end

  always @(negedge clk) if (rst_n) begin
    if (pv) check(desc_valid && desc_offset == poff, "R7 hold", desc_offset, poff);
    pv   = desc_valid && !desc_ready;
    poff = desc_offset;
    if (rd_req && rd_ack) begin
      int a;
      a = (ai == 0) ? cur_base + 4 : cur_base + 12 + 8 * ((ai - 1) / 2) + 4 * ((ai - 1) % 2);
      check(rd_addr == AW'(a), (ai == 0) ? "R2 header addr" : "R4 entry addr", 64'(rd_addr), 64'(a));
      ai++;
    end
    if (desc_valid && desc_ready) begin
      logic [31:0] lo, hi;
      int ea;
      ea = cur_base + 12 + 8 * di;
      lo = mem[ea[11:2]];
      hi = mem[(ea + 4) >> 2];
      check(desc_offset == e_off(lo, hi), "R5 offset", desc_offset, e_off(lo, hi));
      check(desc_bar == lo[2:0], "R5 bar", 64'(desc_bar), 64'(lo[2:0]));
      check(desc_ok == e_ok(lo, hi), "R6 verdict", 64'(desc_ok), 64'(e_ok(lo, hi)));
      check(desc_last == (di == exp_n - 1), "R7 last", 64'(desc_last), 64'(di == exp_n - 1));
      di++;
    end
  end

  task automatic set_len(input int base, input int len);
    mem[(base + 4) >> 2] = {len[11:0], 20'($urandom)};
  endtask

  task automatic fill(input int base, input int n);
    for (int k = 0; k < n; k++) begin
      mem[(base + 12 + 8 * k) >> 2] = $urandom;
      mem[(base + 16 + 8 * k) >> 2] = ($urandom % 2 == 0) ? 32'd0 : 32'($urandom % 3);
    end
    for (int i = 0; i < NBAR; i++)
      bsz[i] = ($urandom % 4 == 0) ? 64'hFFFF_FFFF_FFFF_FFFF : {32'($urandom % 3), 32'($urandom)};
  endtask

  task automatic walk(input int base, input int len, input bit glitch);
    bit seen_done;
    exp_n = (len < 12) ? 0 : (len - 12) / 8;
    cur_base = base; ai = 0; di = 0; seen_done = 0;
    @(negedge clk);
    base_addr = AW'(base); start = 1;
    @(negedge clk);
    start = 0;
    for (int c = 0; c < 20000 && !seen_done; c++) begin
      if (glitch && c == 3) begin base_addr = AW'(base + 256); start = 1; end
      else start = 0;
      @(negedge clk);
      if (done) seen_done = 1;
    end
    start = 0;
    check(seen_done, "R8 done pulse", 64'(seen_done), 64'd1);
    check(di == exp_n, "R3 entry count", 64'(di), 64'(exp_n));
    check(ai == 1 + 2 * exp_n, "R8 read total", 64'(ai), 64'(1 + 2 * exp_n));
    @(negedge clk);
    check(!busy && !done, "R8 idle after done", {62'd0, busy, done}, 64'd0);
  endtask

  initial begin
    process::self().srandom(32'd7);
    for (int i = 0; i < 1024; i++) mem[i] = $urandom;
    for (int i = 0; i < NBAR; i++) bsz[i] = '1;
    repeat (3) @(negedge clk);
    check(!busy && !rd_req && !desc_valid && !done, "R1 reset state",
          {60'd0, busy, rd_req, desc_valid, done}, 64'd0);
    rst_n = 1;
    @(negedge clk);

    // R3 lengths with no whole entry
    set_len(16'h100, 8);    walk(16'h100, 8, 0);
    set_len(16'h100, 12);   walk(16'h100, 12, 0);
    set_len(16'h100, 19);   walk(16'h100, 19, 0);
    // R3 single entry at 0x14 and floor at 0x1B
    fill(16'h200, 1); set_len(16'h200, 20); walk(16'h200, 20, 0);
    fill(16'h200, 1); set_len(16'h200, 27); walk(16'h200, 27, 0);
    fill(16'h200, 2); set_len(16'h200, 28); walk(16'h200, 28, 0);

    // R6 boundary: size equal to offset, one below, indicator outside table
    mem[(16'h300 + 12) >> 2] = 32'h1234_0002; mem[(16'h300 + 16) >> 2] = 32'h1;
    mem[(16'h300 + 20) >> 2] = 32'h1234_0003; mem[(16'h300 + 24) >> 2] = 32'h1;
    mem[(16'h300 + 28) >> 2] = 32'h0000_0006; mem[(16'h300 + 32) >> 2] = 32'h0;
    mem[(16'h300 + 36) >> 2] = 32'h0000_0007; mem[(16'h300 + 40) >> 2] = 32'h0;
    bsz[2] = 64'h1_1234_0000; bsz[3] = 64'h1_1233_FFFF;
    set_len(16'h300, 44); walk(16'h300, 44, 0);

    // R8 start while busy is ignored
    fill(16'h400, 3); set_len(16'h400, 36); walk(16'h400, 36, 1);

    for (int t = 0; t < 40; t++) begin
      int b, l;
      b = 4 * ($urandom % 512);
      l = $urandom % 160;
      fill(b, (l < 12) ? 0 : (l - 12) / 8);
      set_len(b, l);
      walk(b, l, ($urandom % 4) == 0);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #1500000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule